// File: doc/BRIEF.md
# Programmable Sinc3/Sinc4 Decimation Filter with Settling Control

This block turns a one-bit sigma-delta stream into signed 24-bit conversion words. Each input bit comes with a strobe. Bit 1 counts as +1 and bit 0 counts as −1. The bits pass through a cascade of integrators running at the sample rate. A cascade of differentiators runs at the decimated rate. The decimation ratio is D = 1024 × `rate_code`, and `rate_code` is a 10-bit value between 1 and 1023. A select input chooses a filter order N of three or four while the block is running.

The block also decides which words are trustworthy. The filter needs N complete output periods after a restart before its window is full of fresh samples. Any result produced before that is withheld. Three things cause a restart:
- a pulse on the channel-change input;
- any change of the rate code;
- any change of the order select.

With zero latency off, results then follow once per period. With zero latency on, every result waits a full settling interval. The conversion time is then N·D samples, whether one channel or many are being scanned. A step in the input is not detected and does not restart anything. The output rate stays the same, and the words settle after N periods.

Top module: `sinc_decim`

## Requirements
- R1: While `rate_code` is 0, no sample is accepted, the filter is held clear and `res_valid` stays low. Moving to a legal code acts as a restart (R10).
- R2: With zero latency off, once settled, valid pulses come one per D = 1024·`rate_code` accepted samples. With a strobe on every clock, that is one pulse every D clocks.
- R3: Input bit 1 means +1 and bit 0 means −1. The result is the N-fold boxcar sum S of the window, shifted right arithmetically by N·(10+L) − 22, where L = ceil(log2 `rate_code`). The low 24 bits of that value are output. Some examples for FS=1, sinc3:
  - all ones gives +4194304;
  - all zeros gives −4194304;
  - an alternating pattern gives 0.
- R4: `sel_sinc3` = 1 selects third order (N=3) and 0 selects fourth order (N=4). Both the result scaling and the settling length follow N.
- R5: After a restart, results that are not settled are suppressed. The first valid result covers exactly N·D samples. With a strobe every clock, it appears just after the (N·D+1)-th clock edge that follows the restart edge.
- R6: `res_valid` is a pulse one clock wide. It is never high in two consecutive cycles.
- R7: A `chan_chg` pulse clears the filter and restarts settling. The sample in that cycle is dropped. A result that would have been registered at the same edge is discarded.
- R8: With `zero_lat` = 1, one result is produced every N·D samples. Each result comes only from the samples taken since the previous result.
- R9: A step in the input is not detected. The output cadence is unchanged. After a step aligned to a period boundary, the (N−1)-th result is still partial and the N-th result is fully settled.
- R10: A change of `rate_code` or `sel_sinc3` restarts the filter exactly as R7 does.
- R11: During reset, `res_valid` is 0 and `res_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bs_bit | input | 1 | Modulator bit: 1 means +1, 0 means −1 |
| bs_stb | input | 1 | Qualifies `bs_bit` for this cycle |
| rate_code | input | 10 | Rate code FS; D = 1024·FS; 0 halts the block |
| sel_sinc3 | input | 1 | 1 selects third order, 0 selects fourth order |
| zero_lat | input | 1 | 1 makes each result wait a full settling interval |
| chan_chg | input | 1 | One-cycle request to restart the filter |
| res_data | output | 24 | Signed conversion result, held between results |
| res_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
Two functions can collide in one cycle: a restart request and the registration of a result whose window has just completed. The bench provokes this by raising `chan_chg` in exactly the clock after the N·D-th sample, which is the cycle in which that result would be registered. It expects no pulse at that edge. It then expects the next pulse only after a complete new settling interval, carrying the correct full-scale value. The same collision is provoked without the pulse by changing the rate code or the order select partway through a window. In both cases the restart must win, and the timing must start again from the edge where the change happened.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  // highest filter order supported and the alternative lower order
  localparam int ORD_MAX = 4;
  localparam int ORD_LO  = 3;

  // counts completed output periods up to ORD_MAX (+1 headroom)
  typedef logic [2:0] ord_cnt_t;

  // ceil(log2(v)) for v >= 1, 0 for v <= 1
  function automatic int ceil_log2(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if ((32'd1 << i) < v) r = i + 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/sinc_integ.sv
module sinc_integ #(
  parameter int ACC_W = 81,
  parameter int NST   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_i,
  input  logic             sel3,
  output logic [ACC_W-1:0] tap_o
);
  logic [ACC_W-1:0] x_val;

  // +1 for a one, -1 (all ones) for a zero
  assign x_val = bit_i ? ACC_W'(1) : '1;

  for (genvar k = 0; k < NST; k++) begin : g_st
    logic [ACC_W-1:0] src;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_n;

    if (k == 0) begin : g_head
      assign src = x_val;
    end else begin : g_link
      assign src = g_st[k-1].acc_q;
    end

    always_comb begin
      acc_n = acc_q;
      if (clr)     acc_n = '0;
      else if (en) acc_n = acc_q + src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_n;
    end
  end

  assign tap_o = sel3 ? g_st[NST-2].acc_q : g_st[NST-1].acc_q;
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
  parameter int ACC_W = 81,
  parameter int NST   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             sel3,
  input  logic [ACC_W-1:0] src_i,
  output logic [ACC_W-1:0] y_o
);
  for (genvar k = 0; k < NST; k++) begin : g_cs
    logic [ACC_W-1:0] in_v;
    logic [ACC_W-1:0] dly_q;
    logic [ACC_W-1:0] dly_n;
    logic [ACC_W-1:0] dif;

    if (k == 0) begin : g_head
      assign in_v = src_i;
    end else begin : g_link
      assign in_v = g_cs[k-1].dif;
    end

    assign dif = in_v - dly_q;

    always_comb begin
      dly_n = dly_q;
      if (clr)     dly_n = '0;
      else if (en) dly_n = in_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= dly_n;
    end
  end

  assign y_o = sel3 ? g_cs[NST-2].dif : g_cs[NST-1].dif;
endmodule

// File: rtl/sinc_seq.sv
module sinc_seq #(
  parameter int FS_W     = 10,
  parameter int BASE_LOG = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb_i,
  input  logic [FS_W-1:0] rate_i,
  input  logic            sel3_i,
  input  logic            zl_i,
  input  logic            chg_i,
  output logic            clr_o,
  output logic            smp_en_o,
  output logic            comb_en_o,
  output logic            emit_o
);
  import sinc_pkg::*;
  localparam int CNT_W = FS_W + BASE_LOG;

  logic [CNT_W-1:0] dec_q, dec_n, dec_top;
  logic             tick_q, tick_n;
  ord_cnt_t         settle_q, settle_n, settle_inc, ord;
  logic [FS_W-1:0]  rate_q;
  logic             sel3_q;
  logic             restart, accept, done;

  always_comb begin
    restart    = chg_i | (rate_i != rate_q) | (sel3_i != sel3_q) | (rate_i == '0);
    dec_top    = {rate_i, {BASE_LOG{1'b0}}} - CNT_W'(1);
    ord        = sel3_i ? ord_cnt_t'(ORD_LO) : ord_cnt_t'(ORD_MAX);
    accept     = stb_i & ~restart;
    settle_inc = settle_q + ord_cnt_t'(1);
    done       = tick_q & ~restart & (settle_inc >= ord);

    dec_n    = dec_q;
    tick_n   = 1'b0;
    settle_n = settle_q;
    if (restart) begin
      dec_n    = '0;
      settle_n = '0;
    end else begin
      if (accept) begin
        if (dec_q == dec_top) begin
          dec_n  = '0;
          tick_n = 1'b1;
        end else begin
          dec_n = dec_q + CNT_W'(1);
        end
      end
      if (tick_q) settle_n = done ? (zl_i ? ord_cnt_t'(0) : ord) : settle_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q    <= '0;
      tick_q   <= 1'b0;
      settle_q <= '0;
      rate_q   <= '0;
      sel3_q   <= 1'b1;
    end else begin
      dec_q    <= dec_n;
      tick_q   <= tick_n;
      settle_q <= settle_n;
      rate_q   <= rate_i;
      sel3_q   <= sel3_i;
    end
  end

  assign clr_o     = restart;
  assign smp_en_o  = accept;
  assign comb_en_o = tick_q & ~restart;
  assign emit_o    = done;

  // R2: a result is only released right after the sample counter wrapped
  a_r2_emit_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    emit_o |-> (dec_q == '0));
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim #(
  parameter int FS_W     = 10,
  parameter int BASE_LOG = 10,
  parameter int OUT_W    = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bs_bit,
  input  logic                    bs_stb,
  input  logic [FS_W-1:0]         rate_code,
  input  logic                    sel_sinc3,
  input  logic                    zero_lat,
  input  logic                    chan_chg,
  output logic signed [OUT_W-1:0] res_data,
  output logic                    res_valid
);
  import sinc_pkg::*;
  localparam int ACC_W = ORD_MAX * (BASE_LOG + FS_W) + 1;
  localparam int HEAD  = OUT_W - 2;

  logic [1:0]       rsync;
  logic             rst_core_n;
  logic             clr, smp_en, comb_en, emit;
  logic [ACC_W-1:0] integ_tap, comb_y;
  int               sh, prod;
  logic [OUT_W-1:0] data_q, data_n;
  logic             valid_q, valid_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_core_n = rsync[1];

  sinc_seq #(.FS_W(FS_W), .BASE_LOG(BASE_LOG)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .stb_i(bs_stb), .rate_i(rate_code),
    .sel3_i(sel_sinc3), .zl_i(zero_lat), .chg_i(chan_chg),
    .clr_o(clr), .smp_en_o(smp_en), .comb_en_o(comb_en), .emit_o(emit));

  sinc_integ #(.ACC_W(ACC_W), .NST(ORD_MAX)) u_integ (
    .clk(clk), .rst_n(rst_core_n), .clr(clr), .en(smp_en),
    .bit_i(bs_bit), .sel3(sel_sinc3), .tap_o(integ_tap));

  sinc_comb #(.ACC_W(ACC_W), .NST(ORD_MAX)) u_comb (
    .clk(clk), .rst_n(rst_core_n), .clr(clr), .en(comb_en),
    .sel3(sel_sinc3), .src_i(integ_tap), .y_o(comb_y));

  // gain is D^N; bring it to +/-2^(OUT_W-2) at power-of-two rate codes
  always_comb begin
    prod    = (sel_sinc3 ? ORD_LO : ORD_MAX) * (BASE_LOG + ceil_log2(32'(rate_code)));
    sh      = (prod > HEAD) ? prod - HEAD : 0;
    valid_n = emit;
    data_n  = data_q;
    if (emit) data_n = OUT_W'($signed(comb_y) >>> sh);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_n;
      valid_q <= valid_n;
    end
  end

  assign res_data  = data_q;
  assign res_valid = valid_q;

  // R6: single-cycle valid
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_core_n)
    res_valid |=> !res_valid);
  // R7: a restart request never lets a result out at its edge
  a_r7_chg_blocks_result: assert property (@(posedge clk) disable iff (!rst_core_n)
    chan_chg |=> !res_valid);
  // R1: a zero rate code produces nothing
  a_r1_zero_rate_silent: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rate_code == '0) |=> !res_valid);
  // R10: a rate change restarts like a channel change
  a_r10_rate_change_restarts: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rate_code != $past(rate_code)) |=> !res_valid);
endmodule

// File: tb/sim_sinc_decim.sv
module sim_sinc_decim;
  localparam int     CLK_NS = 10;
  localparam int     WDOG   = 195000;
  localparam longint FULL   = 64'sd4194304;
  localparam int P_ONE = 0, P_ZERO = 1, P_ALT = 2, P_3Q = 3, P_STEP = 4;

  typedef struct packed {
    logic               s3;
    logic [9:0]         fs;
    logic [2:0]         pat;
    logic signed [23:0] expv;
  } vec_t;

  // stimulus (order, rate, pattern) and expected settled result
  localparam vec_t VECS [8] = '{
    '{1'b1, 10'd1, 3'd0,  24'sd4194304},   // R3 sinc3 ones
    '{1'b1, 10'd1, 3'd1, -24'sd4194304},   // R3 sinc3 zeros
    '{1'b1, 10'd1, 3'd2,  24'sd0},         // R3 alternating
    '{1'b0, 10'd1, 3'd3,  24'sd2097152},   // R4 sinc4 3/4 density
    '{1'b1, 10'd3, 3'd0,  24'sd1769472},   // R3 non power-of-two rate
    '{1'b0, 10'd2, 3'd1, -24'sd4194304},   // R4 sinc4 zeros, FS=2
    '{1'b0, 10'd3, 3'd3,  24'sd663552},    // R4 sinc4 FS=3
    '{1'b1, 10'd3, 3'd2,  24'sd0}          // R3 alternating FS=3
  };

  logic clk = 1'b0;
  logic rst_n, bs_bit, bs_stb, sel_sinc3, zero_lat, chan_chg;
  logic [9:0] rate_code;
  logic signed [23:0] res_data;
  logic res_valid;

  int n_chk = 0, n_err = 0, edges = 0, vcnt = 0;
  longint rlog [8];

  always #(CLK_NS/2) clk = ~clk;

  sinc_decim u0 (
    .clk(clk), .rst_n(rst_n), .bs_bit(bs_bit), .bs_stb(bs_stb),
    .rate_code(rate_code), .sel_sinc3(sel_sinc3), .zero_lat(zero_lat),
    .chan_chg(chan_chg), .res_data(res_data), .res_valid(res_valid));

  function automatic logic pbit(input int pat, input int s, input int step_at);
    case (pat)
      P_ONE:   return 1'b1;
      P_ZERO:  return 1'b0;
      P_ALT:   return (s % 2) == 1;
      P_3Q:    return (s % 4) != 0;
      default: return s > step_at;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_clk();
    @(posedge clk);
    @(negedge clk);
    edges++;
  endtask

  task automatic restart_cfg(input logic s3, input int fs, input logic zl);
    sel_sinc3 = s3; rate_code = 10'(fs); zero_lat = zl;
    chan_chg = 1'b1; bs_stb = 1'b1; bs_bit = 1'b0;
    step_clk();
    chan_chg = 1'b0;
    edges = 0;
  endtask

  task automatic run_plain(input int n, input int pat);
    vcnt = 0;
    for (int i = 0; i < n; i++) begin
      bs_bit = pbit(pat, edges + 1, 0);
      step_clk();
      if (res_valid) vcnt++;
    end
  endtask

  task automatic run_conv(input int ord, input int fs, input logic zl, input int pat,
                          input int step_at, input int nres, input bit chkval,
                          input longint expv, input string tag);
    int d     = 1024 * fs;
    int first = ord * d + 1;
    int per   = zl ? ord * d : d;
    int limit = first + per * (nres - 1) + 8;
    int got   = 0;
    logic prev = 1'b0;
    while (got < nres && edges < limit) begin
      bs_bit = pbit(pat, edges + 1, step_at);
      step_clk();
      if (res_valid) begin
        chk(!prev, "R6 valid one cycle wide", longint'(prev), 0);
        chk(edges == first + got * per,
            (got == 0) ? {tag, " R5 first valid edge"} :
            (zl ? {tag, " R8 spacing"} : {tag, " R2 spacing"}),
            edges, first + got * per);
        rlog[got] = longint'(res_data);
        if (chkval) chk(longint'(res_data) == expv, {tag, " value"}, longint'(res_data), expv);
        got++;
      end
      prev = res_valid;
    end
    chk(got == nres, {tag, " result count"}, got, nres);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WDOG, WDOG);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bs_bit = 1'b0; bs_stb = 1'b0; sel_sinc3 = 1'b1;
    zero_lat = 1'b0; chan_chg = 1'b0; rate_code = 10'd1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(res_valid == 1'b0, "R11 valid in reset", longint'(res_valid), 0);
    chk(res_data == '0, "R11 data in reset", longint'(res_data), 0);
    rst_n = 1'b1;
    repeat (3) step_clk();

    // table walk: R3 / R4 values, R5 first timing, R2 spacing
    for (int i = 0; i < 8; i++) begin
      restart_cfg(VECS[i].s3, int'(VECS[i].fs), 1'b0);
      run_conv(VECS[i].s3 ? 3 : 4, int'(VECS[i].fs), 1'b0, int'(VECS[i].pat), 0, 2, 1'b1,
               longint'(VECS[i].expv), VECS[i].s3 ? "R3 sinc3" : "R4 sinc4");
    end

    // R8: zero latency, both orders
    restart_cfg(1'b0, 1, 1'b1);
    run_conv(4, 1, 1'b1, P_ONE, 0, 2, 1'b1, FULL, "R8 zero-latency sinc4");
    restart_cfg(1'b1, 1, 1'b1);
    run_conv(3, 1, 1'b1, P_ALT, 0, 2, 1'b1, 0, "R8 zero-latency sinc3");

    // R9: step aligned to a period boundary, no restart
    restart_cfg(1'b1, 1, 1'b0);
    run_conv(3, 1, 1'b0, P_STEP, 3072, 4, 1'b0, 0, "R9 step");
    chk(rlog[0] == -FULL, "R9 before step", rlog[0], -FULL);
    chk(rlog[2] <  FULL, "R9 partial after step", rlog[2], FULL - 1);
    chk(rlog[3] == FULL, "R9 settled after step", rlog[3], FULL);

    // R7: restart in the very cycle a result would be registered
    restart_cfg(1'b1, 1, 1'b0);
    run_plain(3072, P_ONE);
    chk(vcnt == 0, "R5 unsettled suppressed", vcnt, 0);
    bs_bit = 1'b1; chan_chg = 1'b1;
    step_clk();
    chan_chg = 1'b0;
    chk(res_valid == 1'b0, "R7 colliding result dropped", longint'(res_valid), 0);
    edges = 0;
    run_conv(3, 1, 1'b0, P_ONE, 0, 1, 1'b1, FULL, "R7 after collision");

    // R10: rate code change mid-window
    restart_cfg(1'b1, 1, 1'b0);
    run_plain(2048, P_ONE);
    chk(vcnt == 0, "R5 no early result", vcnt, 0);
    rate_code = 10'd2; bs_bit = 1'b1;
    step_clk();
    edges = 0;
    run_conv(3, 2, 1'b0, P_ONE, 0, 1, 1'b1, FULL, "R10 rate change");

    // R10: order change mid-window
    restart_cfg(1'b1, 1, 1'b0);
    run_plain(1536, P_ONE);
    sel_sinc3 = 1'b0; bs_bit = 1'b1;
    step_clk();
    edges = 0;
    run_conv(4, 1, 1'b0, P_ONE, 0, 1, 1'b1, FULL, "R10 order change");

    // R1: zero rate code halts, legal code resumes with full settling
    sel_sinc3 = 1'b1; rate_code = 10'd0; chan_chg = 1'b1;
    step_clk();
    chan_chg = 1'b0;
    run_plain(5000, P_ONE);
    chk(vcnt == 0, "R1 zero rate silent", vcnt, 0);
    rate_code = 10'd1; bs_bit = 1'b1;
    step_clk();
    edges = 0;
    run_conv(3, 1, 1'b0, P_ONE, 0, 1, 1'b1, FULL, "R1 resume after zero rate");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule